// File: doc/BRIEF.md
# Audio Frame Sync Generator

This block marks the video frames on which the audio clock dividers start again. It keeps a frame counter that runs modulo n, where n comes from the video frame rate and the audio sample rate. The sync output is active for the whole of line 1 of every frame whose index is 0. A second output gives a one-cycle strobe at the start of that window, which the audio dividers use as their reset.

The phase of the frame counter can be set to zero in two ways: by a 10-field identification reference pulse (this path can be switched off), or by a software strobe. With neither, the counter free-runs and its phase is arbitrary. A polarity input chooses an active-high (default) or active-low output. For 59.94 Hz video with 48 kHz audio, n is 5. With the reference arriving on the first line of every fifth frame, the sync output then lines up with the reference frame by frame.

Top module: `afs_gen`

## Requirements
- R1: While reset is held and after its release (before any line 1 of frame 0), `afs_o` sits at its inactive level, which equals `afs_inv_i`, and `div_rst_o` is 0.
- R2: The active window opens in the cycle after a `line_start_i` pulse with `line_num_i` equal to 1 in a frame of index 0. It closes in the cycle after the next `line_start_i` pulse whose `line_num_i` is not 1. Between these `line_start_i` pulses the window holds its level.
- R3: On each `frame_start_i` with no reset event, the frame index advances by one and wraps to 0 after n_eff-1, where n_eff = `n_sel_i` if `n_sel_i` >= 2 and 1 otherwise.
- R4: A `n_sel_i` of 0 or 1 gives n_eff = 1, so the window opens on line 1 of every frame.
- R5: With `ref_en_i` = 1, a `ref_pulse_i` sets the frame index to 0: immediately if it comes with `frame_start_i`, otherwise at the next `frame_start_i`.
- R6: With `ref_en_i` = 0, `ref_pulse_i` has no effect on the outputs.
- R7: `sw_rst_i` resets the frame index just as R5 does, whatever the value of `ref_en_i`.
- R8: With no reset events, the window repeats every n_eff frames. Reset leaves the index at 0, so the first `frame_start_i` after reset gives index 1 (or 0 when n_eff = 1).
- R9: With `afs_inv_i` = 1, `afs_o` is the complement of the active-high window.
- R10: `div_rst_o` is a single-cycle pulse. It shows in the first cycle of each window (the cycle after the opening `line_start_i`) and at no other time.
- R11: With n = 5 and a reference pulse given together with `frame_start_i` every fifth frame, the window occurs in exactly the frames that carry the reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start_i | input | 1 | One-cycle pulse at the start of a frame; it coincides with the line-start of line 1 |
| line_start_i | input | 1 | One-cycle pulse at the start of each line |
| line_num_i | input | 11 | Number of the current line, counted from 1; valid when `line_start_i` is high |
| ref_pulse_i | input | 1 | 10-field identification reference pulse |
| ref_en_i | input | 1 | 1 lets the reference reset the frame index |
| sw_rst_i | input | 1 | Software strobe that resets the frame index |
| afs_inv_i | input | 1 | 1 makes `afs_o` active-low |
| n_sel_i | input | 4 | Frame divide ratio n; 0 and 1 both mean 1 |
| afs_o | output | 1 | Audio frame sync signal |
| div_rst_o | output | 1 | One-cycle divider-reset strobe |

## Verification
The assertions assume well-formed video timing. `frame_start_i` only ever comes together with a `line_start_i` whose `line_num_i` is 1, and `line_num_i` changes only at a line start. The bench builds every frame from lines numbered 1 upward, with at least two lines per frame and at least two cycles per line, so these rules hold. Reference and software strobes, n and polarity are drawn at random within those limits, and a few directed runs target the short-ratio, disabled-reference and reference-aligned cases.

// File: rtl/afs_pkg.sv
package afs_pkg;
    localparam int unsigned AFS_N_W     = 4;
    localparam int unsigned AFS_LINE_W  = 11;
    localparam int unsigned AFS_FIRST_LN = 1;

    typedef struct packed {
        logic act;
        logic stb;
    } gate_st_t;
endpackage

// File: rtl/afs_frame_div.sv
module afs_frame_div #(
    parameter int unsigned N_W = afs_pkg::AFS_N_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_start_i,
    input  logic           ref_pulse_i,
    input  logic           ref_en_i,
    input  logic           sw_rst_i,
    input  logic [N_W-1:0] n_sel_i,
    output logic           sel_frame_o
);
    typedef struct packed {
        logic [N_W-1:0] idx;
        logic           pend;
    } div_st_t;

    div_st_t        st_q, st_d;
    logic [N_W-1:0] n_eff;
    logic [N_W-1:0] n_last;
    logic           rst_evt;

    always_comb begin
        n_eff   = (n_sel_i < N_W'(2)) ? N_W'(1) : n_sel_i;
        n_last  = n_eff - N_W'(1);
        rst_evt = sw_rst_i | (ref_pulse_i & ref_en_i);
        st_d    = st_q;
        if (frame_start_i) begin
            if (rst_evt || st_q.pend) begin
                st_d.idx = '0;
            end else if (st_q.idx >= n_last) begin
                st_d.idx = '0;
            end else begin
                st_d.idx = st_q.idx + N_W'(1);
            end
            st_d.pend = 1'b0;
        end else if (rst_evt) begin
            st_d.pend = 1'b1;
        end
        sel_frame_o = frame_start_i ? (st_d.idx == '0) : (st_q.idx == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    a_r5_ref_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start_i && ref_pulse_i && ref_en_i) |=> (st_q.idx == '0));
    a_r7_sw_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start_i && sw_rst_i) |=> (st_q.idx == '0));
    a_r3_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start_i |=> $stable(st_q.idx));
    a_r4_unit_ratio: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start_i && n_sel_i < N_W'(2)) |=> (st_q.idx == '0));
endmodule

// File: rtl/afs_line_gate.sv
module afs_line_gate
    import afs_pkg::*;
#(
    parameter int unsigned LINE_W   = AFS_LINE_W,
    parameter int unsigned FIRST_LN = AFS_FIRST_LN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start_i,
    input  logic [LINE_W-1:0] line_num_i,
    input  logic              sel_frame_i,
    output logic              act_o,
    output logic              stb_o
);
    localparam logic [LINE_W-1:0] OPEN_LN = LINE_W'(FIRST_LN);

    gate_st_t gate_q, gate_d;
    logic     open_now;

    always_comb begin
        open_now   = line_start_i && (line_num_i == OPEN_LN) && sel_frame_i;
        gate_d     = gate_q;
        gate_d.stb = open_now;
        if (line_start_i) begin
            gate_d.act = open_now;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= '0;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign act_o = gate_q.act;
    assign stb_o = gate_q.stb;

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start_i |=> $stable(gate_q.act));
    a_r2_close: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start_i && line_num_i != OPEN_LN) |=> !gate_q.act);
    a_r10_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        gate_q.stb |-> gate_q.act);
    a_r10_single: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q.stb && !line_start_i) |=> !gate_q.stb);
endmodule

// File: rtl/afs_gen.sv
module afs_gen
    import afs_pkg::*;
#(
    parameter int unsigned N_W      = AFS_N_W,
    parameter int unsigned LINE_W   = AFS_LINE_W,
    parameter int unsigned FIRST_LN = AFS_FIRST_LN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start_i,
    input  logic              line_start_i,
    input  logic [LINE_W-1:0] line_num_i,
    input  logic              ref_pulse_i,
    input  logic              ref_en_i,
    input  logic              sw_rst_i,
    input  logic              afs_inv_i,
    input  logic [N_W-1:0]    n_sel_i,
    output logic              afs_o,
    output logic              div_rst_o
);
    logic sel_frame;
    logic win_act;
    logic win_stb;

    afs_frame_div #(.N_W(N_W)) u_div (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start_i(frame_start_i),
        .ref_pulse_i  (ref_pulse_i),
        .ref_en_i     (ref_en_i),
        .sw_rst_i     (sw_rst_i),
        .n_sel_i      (n_sel_i),
        .sel_frame_o  (sel_frame)
    );

    afs_line_gate #(.LINE_W(LINE_W), .FIRST_LN(FIRST_LN)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_start_i(line_start_i),
        .line_num_i  (line_num_i),
        .sel_frame_i (sel_frame),
        .act_o       (win_act),
        .stb_o       (win_stb)
    );

    assign afs_o     = win_act ^ afs_inv_i;
    assign div_rst_o = win_stb;

    a_r10_strobe_active: assert property (@(posedge clk) disable iff (!rst_n)
        div_rst_o |-> (afs_o != afs_inv_i));
endmodule

// File: tb/sim_afs_gen.sv
`timescale 1ns/1ps
module sim_afs_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fs = 1'b0, ls = 1'b0;
    logic [10:0] ln = 11'd1;
    logic        refp = 1'b0, ref_en = 1'b1, swr = 1'b0, inv = 1'b0;
    logic [3:0]  nsel = 4'd5;
    logic        afs, drst;

    int total = 0;
    int bad = 0;
    int strobes = 0;
    int stray = 0;
    bit done = 1'b0;

    int  m_idx = 0;
    bit  m_pend = 0, m_act = 0, m_stb = 0;

    always #2.5 clk = ~clk;

    afs_gen u0 (
        .clk(clk), .rst_n(rst_n), .frame_start_i(fs), .line_start_i(ls),
        .line_num_i(ln), .ref_pulse_i(refp), .ref_en_i(ref_en),
        .sw_rst_i(swr), .afs_inv_i(inv), .n_sel_i(nsel),
        .afs_o(afs), .div_rst_o(drst)
    );

    function automatic int neff(input logic [3:0] n);
        return (n < 4'd2) ? 1 : int'(n);
    endfunction

    // reference model built from R2..R10
    always @(posedge clk) begin
        if (!rst_n) begin
            m_idx = 0; m_pend = 0; m_act = 0; m_stb = 0;
        end else begin
            bit evt;
            evt = swr || (refp && ref_en);
            if (fs) begin
                if (evt || m_pend) m_idx = 0;
                else if (m_idx >= neff(nsel) - 1) m_idx = 0;
                else m_idx = m_idx + 1;
                m_pend = 0;
            end else if (evt) begin
                m_pend = 1;
            end
            m_stb = ls && (ln == 11'd1) && (m_idx == 0);
            if (ls) m_act = m_stb;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // p_ref/p_sw in percent; ref_period>0 puts the reference on frame_start of every ref_period-th frame
    task automatic run(input string tag, input int frames, input int lines, input int len,
                       input int p_ref, input int p_sw, input int ref_period);
        bit cur_ref = 0;
        strobes = 0; stray = 0;
        for (int f = 0; f < frames; f++) begin
            for (int l = 1; l <= lines; l++) begin
                for (int c = 0; c < len; c++) begin
                    @(negedge clk);
                    chk({tag, " afs"}, afs, m_act ^ inv);
                    chk({tag, " div_rst R10"}, drst, m_stb);
                    if (drst) begin
                        strobes++;
                        if (!cur_ref) stray++;
                    end
                    ls = (c == 0);
                    fs = (c == 0) && (l == 1);
                    ln = 11'(l);
                    if (ref_period > 0) begin
                        refp = fs && ((f % ref_period) == 0);
                        if (fs) cur_ref = refp;
                    end else begin
                        refp = ($urandom % 100) < p_ref;
                        cur_ref = 1;
                    end
                    swr = ($urandom % 100) < p_sw;
                end
            end
        end
        @(negedge clk);
        chk({tag, " afs tail"}, afs, m_act ^ inv);
        ls = 0; fs = 0; refp = 0; swr = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5a17));
        repeat (3) @(negedge clk);
        chk("R1 afs in reset", afs, 1'b0);
        chk("R1 div_rst in reset", drst, 1'b0);
        inv = 1'b1;
        @(negedge clk);
        chk("R1 afs inactive level inverted", afs, 1'b1);
        inv = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 afs after release", afs, 1'b0);

        // free-run, ratio 3: first active frame is the third
        nsel = 4'd3;
        run("R2 R3 R8 freerun n3", 12, 5, 6, 0, 0, 0);
        chk("R8 window count n3", 1'(strobes == 4), 1'b1);

        nsel = 4'd0;
        run("R4 n0", 6, 4, 5, 0, 0, 0);
        chk("R4 every frame n0", 1'(strobes == 6), 1'b1);
        nsel = 4'd1;
        run("R4 n1", 6, 3, 4, 0, 0, 0);
        chk("R4 every frame n1", 1'(strobes == 6), 1'b1);

        nsel = 4'd4; ref_en = 1'b1;
        run("R5 ref reset", 20, 4, 5, 3, 0, 0);

        nsel = 4'd5; ref_en = 1'b0;
        run("R6 ref ignored", 20, 4, 5, 10, 0, 0);
        chk("R6 ratio kept with ref off", 1'(strobes == 4), 1'b1);

        nsel = 4'd6; ref_en = 1'b0;
        run("R7 sw reset", 20, 4, 5, 0, 3, 0);

        inv = 1'b1; nsel = 4'd4;
        run("R9 inverted", 12, 4, 5, 0, 0, 0);
        inv = 1'b0;

        nsel = 4'd5; ref_en = 1'b1;
        run("R11 ref every 5 frames", 25, 4, 6, 0, 0, 5);
        chk("R11 window count", 1'(strobes == 5), 1'b1);
        chk("R11 no window off reference", 1'(stray == 0), 1'b1);

        for (int k = 0; k < 10; k++) begin
            nsel = 4'($urandom % 16);
            ref_en = 1'($urandom % 2);
            inv = 1'($urandom % 2);
            run("R2 R5 R7 R9 random mix", 8, 2 + int'($urandom % 4), 2 + int'($urandom % 6), 4, 2, 0);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule